// File: doc/BRIEF.md
# Synchronous answer-to-reset shifter

This block drives a fixed 32-bit answer-to-reset word onto a card-style serial data pad. The host raises a reset line, gives at least one clock pulse while that line is high, then lowers it. The first bit of the word then appears on the data output, and each later falling edge of the card clock moves to the next bit. After the last bit the pad is released. The word is set when the block is built, through a parameter.

A reset pulse that arrives in the middle of an answer has two possible effects. If a clock pulse falls inside the pulse, the answer starts again at bit 0. If no clock falls inside it, the answer is aborted and the block returns to standby. While a nonvolatile write is in progress, reset pulses are ignored. The card pins are sampled by a faster system clock, and the inputs are assumed to be synchronised already. Each pin edge is detected from one registered copy of that pin.

Top module: `atr_shifter`

## Requirements
- R1: A card reset pulse that contains a rising card-clock edge, ending while `wr_busy_i` is low, starts an answer. Two system cycles after reset falls, `oe_o` is 1 and `data_o` carries bit 0 of the word.
- R2: Bit k of the answer is bit k of `PATTERN`. The default is 32'h55AA2019, so the bytes 0x19, 0x20, 0xAA and 0x55 go out in that order, each LSB first. The bit index advances on each falling card-clock edge while card reset is low.
- R3: After the 32nd falling card-clock edge of an answer, `oe_o` returns to 0 and `data_o` returns to 1 (released).
- R4: A card reset pulse that ends while `wr_busy_i` is 1 has no effect. No answer starts from standby, and an answer in progress keeps its current bit.
- R5: A valid reset pulse (one that contains a clock) during an answer restarts the answer at bit 0.
- R6: A reset pulse with no rising card-clock edge inside it, during an answer, aborts the answer: `oe_o` goes to 0.
- R7: Card-clock edges while card reset is high do not advance the bit index.
- R8: `rst_ni` low asynchronously forces standby: `oe_o` is 0 and `data_o` is 1.
- R9: Card-clock pulses in standby, with no reset pulse, do not start an answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| card_rst_i | input | 1 | Synchronised card reset pin |
| card_clk_i | input | 1 | Synchronised card clock pin |
| wr_busy_i | input | 1 | Nonvolatile write in progress |
| data_o | output | 1 | Serial answer bit, 1 when released |
| oe_o | output | 1 | Pad drive enable for the answer |

## Verification
The assertions assume that the card clock is low whenever card reset falls. This is the non-overlap rule, and it stops a clock fall from landing in the same cycle as the start of an answer. They also assume that every pin level is held for more than one system cycle. The stimulus meets both assumptions. It changes pins only at falling system-clock edges and holds each level for three system cycles. Every reset pulse ends with the card clock low, and the bench reads the outputs three cycles after each pin change.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int unsigned PIN_CLK = 0;
  localparam int unsigned PIN_RST = 1;
  localparam int unsigned PIN_N   = 2;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_START   = 2'd1,
    EV_ABORT   = 2'd2
  } win_ev_e;
endpackage

// File: rtl/atr_edge_det.sv
module atr_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] pin_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_q[g] <= 1'b0;
      else         pin_q[g] <= pin_i[g];
    end
    assign rise_o[g] = pin_i[g] & ~pin_q[g];
    assign fall_o[g] = ~pin_i[g] & pin_q[g];
  end
endmodule

// File: rtl/atr_window.sv
module atr_window
  import atr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rst_level_i,
  input  logic    rst_rise_i,
  input  logic    rst_fall_i,
  input  logic    clk_rise_i,
  output win_ev_e ev_o
);
  logic seen_q;

  // remember whether a card clock rose inside the reset window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       seen_q <= 1'b0;
    else if (rst_rise_i)               seen_q <= 1'b0;
    else if (rst_level_i && clk_rise_i) seen_q <= 1'b1;
  end

  always_comb begin
    ev_o = EV_NONE;
    if (rst_fall_i) ev_o = (seen_q || clk_rise_i) ? EV_START : EV_ABORT;
  end

  assert_clk_seen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_level_i && clk_rise_i && !rst_rise_i) |=> (seen_q || !rst_ni));
endmodule

// File: rtl/atr_shift.sv
module atr_shift #(
  parameter int unsigned          PAT_W   = 32,
  parameter logic [PAT_W-1:0]     PATTERN = 32'h55AA2019
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic step_i,
  input  logic hold_i,
  output logic data_o,
  output logic oe_o
);
  localparam int unsigned IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAT_W - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (active_q && step_i) begin
      if (idx_q == LAST) active_q <= 1'b0;
      else               idx_q    <= idx_q + 1'b1;
    end
  end

  assign oe_o   = active_q;
  assign data_o = active_q ? PATTERN[idx_q] : 1'b1;

  assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_q && idx_q == '0));
  assert_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !start_i) |=> !active_q);
  assert_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && step_i && idx_q == LAST && !start_i && !abort_i) |=> !oe_o);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && step_i && idx_q != LAST && !start_i && !abort_i)
      |=> (idx_q == $past(idx_q) + 1'b1));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !start_i) |=> $stable(idx_q));
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter
  import atr_pkg::*;
#(
  parameter int unsigned      PAT_W   = 32,
  parameter logic [PAT_W-1:0] PATTERN = 32'h55AA2019
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_rst_i,
  input  logic card_clk_i,
  input  logic wr_busy_i,
  output logic data_o,
  output logic oe_o
);
  logic [PIN_N-1:0] pins, rise, fall;
  win_ev_e          ev;
  logic             start, abort, step;

  assign pins[PIN_CLK] = card_clk_i;
  assign pins[PIN_RST] = card_rst_i;

  atr_edge_det #(.N(PIN_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .rise_o (rise),
    .fall_o (fall)
  );

  atr_window u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_level_i (card_rst_i),
    .rst_rise_i  (rise[PIN_RST]),
    .rst_fall_i  (fall[PIN_RST]),
    .clk_rise_i  (rise[PIN_CLK]),
    .ev_o        (ev)
  );

  // busy write blocks both outcomes of a reset pulse
  assign start = (ev == EV_START) && !wr_busy_i;
  assign abort = (ev == EV_ABORT) && !wr_busy_i;
  assign step  = fall[PIN_CLK] && !card_rst_i;

  atr_shift #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .step_i  (step),
    .hold_i  (card_rst_i),
    .data_o  (data_o),
    .oe_o    (oe_o)
  );

  assert_nol_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall[PIN_RST] |-> !card_clk_i);
  assert_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_busy_i && !oe_o) |=> !oe_o);
  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> data_o);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_o && !fall[PIN_RST]) |=> !oe_o);
endmodule

// File: tb/atr_shifter_tb_top.sv
module atr_shifter_tb_top;
  localparam logic [7:0] ATR_BYTES [4] = '{8'h19, 8'h20, 8'hAA, 8'h55};

  logic clk = 1'b0, rst_n = 1'b0;
  logic crst = 1'b0, cclk = 1'b0, busy = 1'b0;
  logic data, oe;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  atr_shifter dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .card_rst_i (crst),
    .card_clk_i (cclk),
    .wr_busy_i  (busy),
    .data_o     (data),
    .oe_o       (oe)
  );

  function automatic logic exp_bit(int k);
    return ATR_BYTES[k / 8][k % 8];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpulse();
    cclk = 1'b1; wait_n(3);
    cclk = 1'b0; wait_n(3);
  endtask

  task automatic rst_pulse(int nclk);
    crst = 1'b1; wait_n(3);
    for (int i = 0; i < nclk; i++) cpulse();
    crst = 1'b0; wait_n(3);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    wait_n(3);
    chk("R8 reset oe", oe, 1'b0);
    chk("R8 reset data", data, 1'b1);
    rst_n = 1'b1; wait_n(2);

    for (int i = 0; i < 3; i++) cpulse();
    chk("R9 idle clocks", oe, 1'b0);

    rst_pulse(1);
    chk("R1 start oe", oe, 1'b1);
    chk("R1 bit0", data, exp_bit(0));
    for (int k = 0; k < 32; k++) begin
      chk("R2 oe", oe, 1'b1);
      chk("R2 bit", data, exp_bit(k));
      cpulse();
    end
    chk("R3 end oe", oe, 1'b0);
    chk("R3 end data", data, 1'b1);

    rst_pulse(3);
    chk("R7 oe", oe, 1'b1);
    chk("R7 bit0 after window clocks", data, exp_bit(0));

    for (int i = 0; i < 5; i++) cpulse();
    chk("R5 pre bit5", data, exp_bit(5));
    rst_pulse(1);
    chk("R5 restart oe", oe, 1'b1);
    chk("R5 restart bit0", data, exp_bit(0));
    cpulse();
    chk("R5 bit1 after restart", data, exp_bit(1));

    cpulse(); cpulse();
    rst_pulse(0);
    chk("R6 abort oe", oe, 1'b0);
    chk("R6 abort data", data, 1'b1);

    busy = 1'b1;
    rst_pulse(1);
    chk("R4 busy no start", oe, 1'b0);
    busy = 1'b0;
    rst_pulse(1);
    cpulse(); cpulse();
    chk("R4 pre bit2", data, exp_bit(2));
    busy = 1'b1;
    rst_pulse(1);
    chk("R4 busy keeps oe", oe, 1'b1);
    chk("R4 busy keeps bit2", data, exp_bit(2));
    busy = 1'b0;
    cpulse();
    chk("R4 continues bit3", data, exp_bit(3));

    rst_n = 1'b0; #1;
    chk("R8 async oe", oe, 1'b0);
    chk("R8 async data", data, 1'b1);
    wait_n(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule